// File: doc/BRIEF.md
# Training-Correlation Symbol and Block Synchronizer

This block sits after the receive matched filters of a two-antenna space-time receiver. It takes complex samples at three samples per symbol on two receive channels and decides which of the three sample phases to keep. It also decides where each two-symbol space-time block begins. It emits one sample per symbol on both channels, a marker on the first symbol of every block, and a lock flag. Both decisions rest on one thing. A known ±1 training word is inserted into the transmitted stream at a fixed interval, and the block correlates channel 1 against that word on every candidate phase.

Symbols are counted from the first accepted sample after reset, and the count is grouped into search windows one training interval long. At the end of each window, the strongest correlation peak seen in that window is the candidate. A candidate consists of its phase and the symbol slot at which the training word ended. Two matching candidates in a row declare lock and set the output phase and the block alignment. Repeated misses then release the lock. The phase and alignment chosen from channel 1 are applied to channel 2 as well.

Top module: `symbol_block_sync`

## Requirements
- R1: While in_valid is high, every accepted sample advances a sample-phase counter that runs 0,1,2, and every third accepted sample ends a symbol. Exactly one output is produced per symbol: the sample accepted at the selected phase. Both channels are taken from that same sample instant.
- R2: A cycle with in_valid low changes no state, and whatever is on the sample inputs in that cycle never reaches an output.
- R3: For each phase, channel 1 is correlated against the training word. Bit k of TRAIN_SEQ is the k-th transmitted training symbol, with 1 meaning +1 and 0 meaning -1. The metric is |Re|+|Im| of the correlation over the latest TRAIN_LEN symbols of that phase, and it is evaluated at the end of every symbol.
- R4: A window spans TRAIN_PERIOD symbols, with window boundaries at symbol counts that are multiples of TRAIN_PERIOD from reset. Its candidate is the largest metric in the window. On a tie, the lower phase and the earlier slot win. The candidate is valid only if that metric is at least MIN_PEAK.
- R5: When unlocked, lock is declared at the end of a window whose valid candidate has the same phase and the same peak slot as the valid candidate of the window before.
- R6: The selected phase and the block alignment change only when lock is declared. Before the first lock the selected phase is 0. After a lock is lost they keep their last values.
- R7: While locked, a window whose candidate is invalid, or differs in phase or slot from the locked values, counts as a miss. A matching window clears the miss count. After MISS_LIMIT (3) consecutive misses, locked falls.
- R8: blk_start is high with an output only when the design was locked at the time that sample was taken, and only if the output's symbol slot (its count modulo TRAIN_PERIOD) has the opposite parity to the locked peak slot. Slot parity flips at every symbol, so each pair of symbols after the training word forms one block.
- R9: After reset, locked, out_valid and blk_start are low.
- R10: The output registers update on the clock edge that accepts the selected-phase sample, so out_valid is high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample accepted this cycle |
| rx1_i | input | SAMP_W | Channel 1 in-phase sample |
| rx1_q | input | SAMP_W | Channel 1 quadrature sample |
| rx2_i | input | SAMP_W | Channel 2 in-phase sample |
| rx2_q | input | SAMP_W | Channel 2 quadrature sample |
| out_valid | output | 1 | One decimated symbol present |
| sym1_i | output | SAMP_W | Channel 1 decimated in-phase |
| sym1_q | output | SAMP_W | Channel 1 decimated quadrature |
| sym2_i | output | SAMP_W | Channel 2 decimated in-phase |
| sym2_q | output | SAMP_W | Channel 2 decimated quadrature |
| blk_start | output | 1 | First symbol of a two-symbol block |
| locked | output | 1 | Phase and block timing are locked |

## Verification
A wrong sample-phase counter or a wrong symbol counter shows at the ports within one symbol. The decimated samples carry the wrong phase tag, or outputs are missing or duplicated. A wrong window candidate or a wrong lock decision only surfaces at the next window boundary. It appears there as a lock flag that rises or falls one training interval early or late, or as a different phase once lock is declared. A wrong block alignment flips the parity of blk_start on the first symbol after lock. The stimulus therefore walks through lock, hits interleaved with misses, a strong peak at a different phase while locked, loss of lock, and relock at a new phase and the opposite slot parity.

// File: rtl/stsync_pkg.sv
package stsync_pkg;
  typedef logic signed [31:0] acc_t;
  typedef logic [31:0]        metric_t;

  function automatic acc_t signed_tap(input logic seq_bit, input acc_t v);
    return seq_bit ? v : -v;
  endfunction

  function automatic metric_t abs_sum(input acc_t re, input acc_t im);
    acc_t ar;
    acc_t ai;
    ar = (re < 0) ? -re : re;
    ai = (im < 0) ? -im : im;
    return metric_t'(ar + ai);
  endfunction
endpackage

// File: rtl/phase_correlator.sv
module phase_correlator
  import stsync_pkg::*;
#(
  parameter int          SAMP_W    = 12,
  parameter int          TRAIN_LEN = 16,
  parameter logic [TRAIN_LEN-1:0] TRAIN_SEQ = 16'h3AC9,
  parameter bit          USE_IN    = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [SAMP_W-1:0] din_i,
  input  logic signed [SAMP_W-1:0] din_q,
  output metric_t                  metric
);
  // tap 0 is the newest symbol of this phase
  logic signed [SAMP_W-1:0] line_i [TRAIN_LEN];
  logic signed [SAMP_W-1:0] line_q [TRAIN_LEN];
  logic signed [SAMP_W-1:0] view_i [TRAIN_LEN];
  logic signed [SAMP_W-1:0] view_q [TRAIN_LEN];
  acc_t                     sum_i;
  acc_t                     sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < TRAIN_LEN; t++) begin
        line_i[t] <= '0;
        line_q[t] <= '0;
      end
    end else if (shift_en) begin
      line_i[0] <= din_i;
      line_q[0] <= din_q;
      for (int t = 1; t < TRAIN_LEN; t++) begin
        line_i[t] <= line_i[t-1];
        line_q[t] <= line_q[t-1];
      end
    end
  end

  // The last phase of a symbol is evaluated in the same cycle as its sample
  // arrives, so its view includes the incoming value as the newest tap.
  generate
    if (USE_IN) begin : g_view_in
      always_comb begin
        view_i[0] = din_i;
        view_q[0] = din_q;
        for (int t = 1; t < TRAIN_LEN; t++) begin
          view_i[t] = line_i[t-1];
          view_q[t] = line_q[t-1];
        end
      end
    end else begin : g_view_reg
      always_comb begin
        for (int t = 0; t < TRAIN_LEN; t++) begin
          view_i[t] = line_i[t];
          view_q[t] = line_q[t];
        end
      end
    end
  endgenerate

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int t = 0; t < TRAIN_LEN; t++) begin
      sum_i = sum_i + signed_tap(TRAIN_SEQ[TRAIN_LEN-1-t], acc_t'(view_i[t]));
      sum_q = sum_q + signed_tap(TRAIN_SEQ[TRAIN_LEN-1-t], acc_t'(view_q[t]));
    end
    metric = abs_sum(sum_i, sum_q);
  end
endmodule

// File: rtl/peak_tracker.sv
module peak_tracker
  import stsync_pkg::*;
#(
  parameter int SPS    = 3,
  parameter int PH_W   = 2,
  parameter int SLOT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eval_en,
  input  logic                       win_close,
  input  logic [SPS-1:0][31:0]       metrics,
  input  logic [SLOT_W-1:0]          slot,
  output metric_t                    cand_metric,
  output logic [PH_W-1:0]            cand_phase,
  output logic [SLOT_W-1:0]          cand_slot
);
  metric_t           run_metric;
  logic [PH_W-1:0]   run_phase;
  logic [SLOT_W-1:0] run_slot;
  logic              run_any;
  metric_t           sym_metric;
  logic [PH_W-1:0]   sym_phase;
  logic              take_sym;

  always_comb begin
    sym_metric = metrics[0];
    sym_phase  = '0;
    for (int p = 1; p < SPS; p++) begin
      if (metrics[p] > sym_metric) begin
        sym_metric = metrics[p];
        sym_phase  = PH_W'(p);
      end
    end
    take_sym    = !run_any || (sym_metric > run_metric);
    cand_metric = take_sym ? sym_metric : run_metric;
    cand_phase  = take_sym ? sym_phase  : run_phase;
    cand_slot   = take_sym ? slot       : run_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_metric <= '0;
      run_phase  <= '0;
      run_slot   <= '0;
      run_any    <= 1'b0;
    end else if (eval_en) begin
      if (win_close) begin
        run_any <= 1'b0;
      end else begin
        run_metric <= cand_metric;
        run_phase  <= cand_phase;
        run_slot   <= cand_slot;
        run_any    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import stsync_pkg::*;
#(
  parameter int      PH_W       = 2,
  parameter int      SLOT_W     = 8,
  parameter int      MISS_LIMIT = 3,
  parameter int      MISS_W     = 2,
  parameter metric_t MIN_PEAK   = 32'd2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_close,
  input  metric_t           cand_metric,
  input  logic [PH_W-1:0]   cand_phase,
  input  logic [SLOT_W-1:0] cand_slot,
  output logic              locked,
  output logic [PH_W-1:0]   sel_phase,
  output logic [SLOT_W-1:0] lock_slot,
  output logic [MISS_W-1:0] miss_cnt,
  output logic              lock_evt,
  output logic              miss_evt,
  output logic              drop_evt
);
  logic              prev_ok;
  logic [PH_W-1:0]   prev_phase;
  logic [SLOT_W-1:0] prev_slot;
  logic              cand_ok;
  logic              match_prev;
  logic              match_lock;

  always_comb begin
    cand_ok    = cand_metric >= MIN_PEAK;
    match_prev = cand_ok && prev_ok && (cand_phase == prev_phase) && (cand_slot == prev_slot);
    match_lock = cand_ok && (cand_phase == sel_phase) && (cand_slot == lock_slot);
    lock_evt   = win_close && !locked && match_prev;
    miss_evt   = win_close && locked && !match_lock;
    drop_evt   = miss_evt && (miss_cnt == MISS_W'(MISS_LIMIT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      sel_phase  <= '0;
      lock_slot  <= '0;
      miss_cnt   <= '0;
      prev_ok    <= 1'b0;
      prev_phase <= '0;
      prev_slot  <= '0;
    end else if (win_close) begin
      prev_ok    <= cand_ok;
      prev_phase <= cand_phase;
      prev_slot  <= cand_slot;
      if (lock_evt) begin
        locked    <= 1'b1;
        sel_phase <= cand_phase;
        lock_slot <= cand_slot;
        miss_cnt  <= '0;
      end else if (locked) begin
        if (!miss_evt) begin
          miss_cnt <= '0;
        end else if (drop_evt) begin
          locked   <= 1'b0;
          miss_cnt <= '0;
        end else begin
          miss_cnt <= miss_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/symbol_block_sync.sv
module symbol_block_sync
  import stsync_pkg::*;
#(
  parameter int SAMP_W       = 12,
  parameter int SPS          = 3,
  parameter int TRAIN_LEN    = 16,
  parameter int TRAIN_PERIOD = 256,
  parameter logic [TRAIN_LEN-1:0] TRAIN_SEQ = 16'h3AC9,
  parameter int MIN_PEAK     = 2000,
  parameter int MISS_LIMIT   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] rx1_i,
  input  logic signed [SAMP_W-1:0] rx1_q,
  input  logic signed [SAMP_W-1:0] rx2_i,
  input  logic signed [SAMP_W-1:0] rx2_q,
  output logic                     out_valid,
  output logic signed [SAMP_W-1:0] sym1_i,
  output logic signed [SAMP_W-1:0] sym1_q,
  output logic signed [SAMP_W-1:0] sym2_i,
  output logic signed [SAMP_W-1:0] sym2_q,
  output logic                     blk_start,
  output logic                     locked
);
  localparam int PH_W   = (SPS > 1) ? $clog2(SPS) : 1;
  localparam int SLOT_W = $clog2(TRAIN_PERIOD);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  logic [PH_W-1:0]      sph;
  logic [SLOT_W-1:0]    slot;
  logic                 sym_end;
  logic                 win_close;
  logic                 take_out;
  logic [SPS-1:0][31:0] metrics;
  metric_t              cand_metric;
  logic [PH_W-1:0]      cand_phase;
  logic [SLOT_W-1:0]    cand_slot;
  logic [PH_W-1:0]      sel_phase;
  logic [SLOT_W-1:0]    lock_slot;
  logic [MISS_W-1:0]    miss_cnt;
  logic                 lock_evt;
  logic                 miss_evt;
  logic                 drop_evt;

  assign sym_end   = in_valid && (sph == PH_W'(SPS - 1));
  assign win_close = sym_end && (slot == SLOT_W'(TRAIN_PERIOD - 1));
  assign take_out  = in_valid && (sph == sel_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sph  <= '0;
      slot <= '0;
    end else if (in_valid) begin
      if (sym_end) begin
        sph  <= '0;
        slot <= win_close ? '0 : slot + 1'b1;
      end else begin
        sph <= sph + 1'b1;
      end
    end
  end

  generate
    for (genvar p = 0; p < SPS; p++) begin : g_phase
      phase_correlator #(
        .SAMP_W   (SAMP_W),
        .TRAIN_LEN(TRAIN_LEN),
        .TRAIN_SEQ(TRAIN_SEQ),
        .USE_IN   (p == SPS - 1)
      ) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(in_valid && (sph == PH_W'(p))),
        .din_i   (rx1_i),
        .din_q   (rx1_q),
        .metric  (metrics[p])
      );
    end
  endgenerate

  peak_tracker #(
    .SPS   (SPS),
    .PH_W  (PH_W),
    .SLOT_W(SLOT_W)
  ) u_peak (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_en    (sym_end),
    .win_close  (win_close),
    .metrics    (metrics),
    .slot       (slot),
    .cand_metric(cand_metric),
    .cand_phase (cand_phase),
    .cand_slot  (cand_slot)
  );

  lock_ctrl #(
    .PH_W      (PH_W),
    .SLOT_W    (SLOT_W),
    .MISS_LIMIT(MISS_LIMIT),
    .MISS_W    (MISS_W),
    .MIN_PEAK  (metric_t'(MIN_PEAK))
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_close  (win_close),
    .cand_metric(cand_metric),
    .cand_phase (cand_phase),
    .cand_slot  (cand_slot),
    .locked     (locked),
    .sel_phase  (sel_phase),
    .lock_slot  (lock_slot),
    .miss_cnt   (miss_cnt),
    .lock_evt   (lock_evt),
    .miss_evt   (miss_evt),
    .drop_evt   (drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      blk_start <= 1'b0;
      sym1_i    <= '0;
      sym1_q    <= '0;
      sym2_i    <= '0;
      sym2_q    <= '0;
    end else begin
      out_valid <= take_out;
      blk_start <= take_out && locked && (slot[0] != lock_slot[0]);
      if (take_out) begin
        sym1_i <= rx1_i;
        sym1_q <= rx1_q;
        sym2_i <= rx2_i;
        sym2_q <= rx2_q;
      end
    end
  end
endmodule

// File: rtl/sync_checker.sv
module sync_checker #(
  parameter int PH_W       = 2,
  parameter int MISS_W     = 2,
  parameter int MISS_LIMIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              blk_start,
  input logic              locked,
  input logic              win_close,
  input logic              lock_evt,
  input logic              drop_evt,
  input logic [PH_W-1:0]   sel_phase,
  input logic [MISS_W-1:0] miss_cnt
);
  p_blk_with_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> out_valid && $past(locked));

  p_out_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_lock_at_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_close));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_evt |=> $stable(sel_phase));

  p_drop_by_misses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(drop_evt));

  p_miss_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt < MISS_W'(MISS_LIMIT));

  p_idle_no_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !win_close);
endmodule

bind symbol_block_sync sync_checker #(
  .PH_W      (PH_W),
  .MISS_W    (MISS_W),
  .MISS_LIMIT(MISS_LIMIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .blk_start(blk_start),
  .locked   (locked),
  .win_close(win_close),
  .lock_evt (lock_evt),
  .drop_evt (drop_evt),
  .sel_phase(sel_phase),
  .miss_cnt (miss_cnt)
);

// File: tb/tb_symbol_block_sync.sv
module tb_symbol_block_sync;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 12;
  localparam int PER    = 256;
  localparam int TLEN   = 16;
  localparam logic [15:0] SEQ = 16'h3AC9;
  localparam int NPER   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] rx1_i = '0, rx1_q = '0, rx2_i = '0, rx2_q = '0;
  logic out_valid, blk_start, locked;
  logic signed [W-1:0] sym1_i, sym1_q, sym2_i, sym2_q;

  int checks = 0;
  int errors = 0;
  logic [4*W:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  symbol_block_sync dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rx1_i(rx1_i), .rx1_q(rx1_q), .rx2_i(rx2_i), .rx2_q(rx2_q),
    .out_valid(out_valid), .sym1_i(sym1_i), .sym1_q(sym1_q),
    .sym2_i(sym2_i), .sym2_q(sym2_q), .blk_start(blk_start), .locked(locked)
  );

  // Schedule per window: 0 = data only, 1 = word A, 2 = word B, 3 = word C
  function automatic int sched(input int k);
    case (k)
      0, 1, 3, 6:  return 1;
      7:           return 3;
      10, 11, 12:  return 2;
      default:     return 0;
    endcase
  endfunction
  function automatic int code_phase(input int c);
    return (c == 2) ? 2 : (c == 3) ? 0 : 1;
  endfunction
  function automatic int code_start(input int c);
    return (c == 2) ? 101 : 40;
  endfunction
  function automatic logic [1:0] dbits(input int s);
    logic [31:0] h;
    h = 32'(s) * 32'd1103515245 + 32'd12345;
    return h[17:16];
  endfunction

  task automatic gen(input int s, input int ph, output logic signed [W-1:0] ci, output logic signed [W-1:0] cq);
    int k, j, c, t0, amp, pk;
    logic bi, bq;
    k = s / PER; j = s % PER; c = sched(k); t0 = code_start(c);
    if (c != 0 && j >= t0 && j < t0 + TLEN) begin
      pk = code_phase(c); amp = (ph == pk) ? 100 : 50;
      bi = SEQ[j - t0]; bq = bi;
    end else begin
      pk = (c != 0) ? code_phase(c) : 1; amp = (ph == pk) ? 60 : 30;
      bi = dbits(s)[0]; bq = dbits(s)[1];
    end
    ci = W'(bi ? amp : -amp);
    cq = W'(bq ? amp : -amp);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per decimated output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected output", 1, 0);
      end else begin
        logic [4*W:0] e;
        e = exp_q.pop_front();
        check(sym1_i == e[4*W:3*W+1] && sym1_q == e[3*W:2*W+1], "R1", "ch1 sample", int'(sym1_i), int'($signed(e[4*W:3*W+1])));
        check(sym2_i == e[2*W:W+1] && sym2_q == e[W:1], "R1", "ch2 sample (phase tag)", int'(sym2_q), int'($signed(e[W:1])));
        check(blk_start == e[0], "R8", "blk_start", int'(blk_start), int'(e[0]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m_locked, m_phase, m_par, m_miss, p_ok, p_ph, p_sl, cyc;
    m_locked = 0; m_phase = 0; m_par = 0; m_miss = 0; p_ok = 0; p_ph = 0; p_sl = 0; cyc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!locked && !out_valid && !blk_start, "R9", "reset outputs", int'({locked, out_valid, blk_start}), 0);
    for (int s = 0; s < NPER * PER; s++) begin
      if (s % PER == 0)
        check(int'(locked) == m_locked, (m_locked != 0) ? "R5" : "R7", "locked at window start", int'(locked), m_locked);
      for (int ph = 0; ph < 3; ph++) begin
        logic signed [W-1:0] ci, cq, di, dq;
        if (cyc % 5 == 4) begin
          // idle cycle with junk data: R2
          in_valid = 1'b0; rx1_i = 12'sd999; rx1_q = -12'sd999; rx2_i = 12'sd77; rx2_q = 12'sd77;
          cyc++;
          @(negedge clk);
        end
        gen(s, ph, ci, cq);
        di = W'(s % 1000);
        dq = W'(ph * 500 - 700);
        in_valid = 1'b1; rx1_i = ci; rx1_q = cq; rx2_i = di; rx2_q = dq;
        if (ph == m_phase)
          exp_q.push_back({ci, cq, di, dq, (m_locked != 0) && ((s % PER) % 2 == m_par)});
        cyc++;
        @(negedge clk);
      end
      if (s % PER == PER - 1) begin
        // Reference window decision: R3 R4 R5 R6 R7
        int c, ok, cp, cs;
        c = sched(s / PER); ok = (c != 0); cp = code_phase(c); cs = code_start(c) + TLEN - 1;
        if (m_locked == 0) begin
          if (ok && p_ok && cp == p_ph && cs == p_sl) begin
            m_locked = 1; m_phase = cp; m_par = (cs + 1) % 2; m_miss = 0;
          end
        end else if (ok && cp == m_phase && (cs + 1) % 2 == m_par) begin
          m_miss = 0;
        end else begin
          m_miss++;
          if (m_miss == 3) begin m_locked = 0; m_miss = 0; end
        end
        p_ok = ok; p_ph = cp; p_sl = cs;
      end
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(int'(locked) == m_locked, "R5", "final lock at new phase", int'(locked), m_locked);
    check(exp_q.size() == 0, "R10", "all outputs delivered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule